// File: doc/BRIEF.md
# Timer-Backed Halt Sequencer

This block sequences the deepest low-power state of a small microcontroller that keeps a timer running. When the core executes a halt instruction while the timer-backed halt mode is enabled, the sequencer gates off the CPU clock and every peripheral clock. The exceptions are peripherals fed from a separate clock source and the one timer chosen as the wakeup time base. On entry it also pulses a request to clear the global interrupt mask, so that interrupts can end the halt.

Only two events end the halt. A wakeup-timer interrupt releases the CPU on the next cycle and requests the vector of the lowest-numbered pending wakeup line. A reset request first holds the CPU off for a fixed start-up window of 64 cycles and then requests the reset vector. A reset always wins over an interrupt in the same cycle. Any reset request restarts the start-up window.

A halt strobe while the mode is disabled does not enter this state; it is flagged for a separate full-halt path. A halt while the watchdog runs only raises a watchdog reset if the watchdog-halt bit is set. The state is visible on a debug output.

Top module: `halt_power_seq`

## Requirements
- R1: In the run state, `halt_strobe` with `halt_mode_en`=1, no `rst_req`, and not (`wdg_active`=1 and `wdg_halt_bit`=1) moves the block to the halted state on the next cycle, with `cpu_clk_en`=0.
- R2: On entry to the halted state, `clr_imask` is 1 for exactly the first halted cycle.
- R3: If a wakeup line is already high when the halt is entered, the block stays halted for one cycle only and requests the interrupt vector in the following cycle.
- R4: While halted or in start-up, `periph_clk_en` equals the parameter `ALT_CLK_MASK` (bit i set = peripheral i has its own clock). `tmr_clk_en` has only bit `tmr_sel` set. In the run and vector-fetch states every bit of both buses and `cpu_clk_en` is 1.
- R5: While halted, only `rst_req` or a set bit of `wake_irq` ends the halt. A new `halt_strobe` or a change of `halt_mode_en` has no effect.
- R6: `rst_req` from any state enters start-up. `cpu_clk_en` stays 0 for exactly 64 cycles after the sampling edge. Then `vec_fetch`=1 with `vec_is_reset`=1 and `cpu_clk_en`=1.
- R7: A wakeup interrupt while halted gives `vec_fetch`=1 on the next cycle with `vec_is_reset`=0 and `vec_id` equal to the index of the lowest set bit of `wake_irq`.
- R8: `rst_req` and a wakeup interrupt in the same halted cycle lead to start-up, not to an interrupt vector fetch.
- R9: A `rst_req` during start-up restarts the 64-cycle window from that sampling edge.
- R10: In the run state, `halt_strobe` with `halt_mode_en`=0 leaves the state in run with all clocks on. It raises `full_halt_req` for one cycle.
- R11: A halt with the mode enabled and `wdg_active`=1 enters the halted state with `wdg_rst_req`=0 when `wdg_halt_bit`=0. When `wdg_halt_bit`=1 it stays in run and pulses `wdg_rst_req` for one cycle.
- R12: `dbg_state` encodes run=0, halted=1, start-up=2, vector fetch=3. After reset the block is in run with `vec_fetch`=0.
- R13: The vector-fetch state lasts one cycle and is followed by run when no `rst_req` is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_strobe | input | 1 | One-cycle pulse: halt instruction executed |
| halt_mode_en | input | 1 | Enable for the timer-backed halt mode |
| wdg_active | input | 1 | Watchdog is running |
| wdg_halt_bit | input | 1 | Watchdog-halt control: 1 = halt causes watchdog reset |
| rst_req | input | 1 | Reset request (wakes with start-up delay) |
| wake_irq | input | NUM_WAKE | Wakeup-timer interrupt requests |
| tmr_sel | input | TSW | Index of the timer kept clocked while halted |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | NUM_PERIPH | Peripheral clock enables |
| tmr_clk_en | output | NUM_TMR | Timer counter clock enables |
| clr_imask | output | 1 | Pulse: clear the global interrupt mask |
| vec_fetch | output | 1 | Vector fetch request |
| vec_is_reset | output | 1 | 1 = reset vector, 0 = interrupt vector |
| vec_id | output | IDW | Wakeup line whose vector is fetched |
| full_halt_req | output | 1 | Pulse: halt seen with the mode disabled |
| wdg_rst_req | output | 1 | Pulse: halt causes watchdog reset |
| dbg_state | output | 2 | Current state encoding |

## Verification
A stimulus sampled at one rising edge shows its effect just after that edge. The new state, the clock enables and the one-cycle pulses `clr_imask`, `full_halt_req` and `wdg_rst_req` all appear together. An interrupt wake therefore shows `vec_fetch` one cycle after the wakeup line is seen. A reset wake shows it 65 cycles after the `rst_req` edge: 64 start-up cycles, then the fetch cycle. The bench drives inputs and reads outputs at falling edges. It counts exactly the rising edges between stimulus and sample, so each check lands in the cycle where the result is due.

// File: rtl/halt_pkg.sv
package halt_pkg;
  typedef enum logic [1:0] {
    PS_RUN     = 2'd0,
    PS_HALTED  = 2'd1,
    PS_STARTUP = 2'd2,
    PS_VFETCH  = 2'd3
  } pstate_e;
endpackage

// File: rtl/halt_wake_enc.sv
// Lowest-index-wins encoder over the wakeup request lines.
module halt_wake_enc #(
  parameter int NUM_WAKE = 4,
  parameter int IDW      = (NUM_WAKE > 1) ? $clog2(NUM_WAKE) : 1
) (
  input  logic [NUM_WAKE-1:0] irq_i,
  output logic                any_o,
  output logic [IDW-1:0]      id_o
);
  always_comb begin
    id_o = '0;
    for (int i = NUM_WAKE - 1; i >= 0; i--) begin
      if (irq_i[i]) id_o = IDW'(i);
    end
  end

  assign any_o = |irq_i;
endmodule

// File: rtl/halt_delay_cnt.sv
// Start-up window counter; cleared by any reset request.
module halt_delay_cnt #(
  parameter int CYCLES = 64,
  localparam int CW    = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                 cnt_d = '0;
    else if (run_i && !done_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: a reset request restarts the window
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  // R6: the count never runs past the window
  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/halt_fsm.sv
// Power-mode state machine with vector selection and entry pulses.
module halt_fsm
  import halt_pkg::*;
#(
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           halt_strobe_i,
  input  logic           mode_en_i,
  input  logic           wdg_active_i,
  input  logic           wdg_halt_bit_i,
  input  logic           rst_req_i,
  input  logic           wake_any_i,
  input  logic [IDW-1:0] wake_id_i,
  input  logic           delay_done_i,
  output pstate_e        state_o,
  output logic           vec_is_reset_o,
  output logic [IDW-1:0] vec_id_o,
  output logic           clr_imask_o,
  output logic           full_halt_o,
  output logic           wdg_rst_o
);
  pstate_e        state_q, state_d;
  logic           vec_rst_q, vec_rst_d;
  logic [IDW-1:0] vec_id_q, vec_id_d;
  logic           clr_q, full_q, wdg_q;
  logic           wdg_block, halt_ok, in_run;

  assign in_run    = (state_q == PS_RUN) && !rst_req_i;
  assign wdg_block = wdg_active_i && wdg_halt_bit_i;
  assign halt_ok   = halt_strobe_i && mode_en_i && !wdg_block;

  always_comb begin
    state_d   = state_q;
    vec_rst_d = vec_rst_q;
    vec_id_d  = vec_id_q;
    if (rst_req_i) begin
      state_d = PS_STARTUP;
    end else begin
      unique case (state_q)
        PS_RUN:     if (halt_ok) state_d = PS_HALTED;
        PS_HALTED:  if (wake_any_i) begin
                      state_d   = PS_VFETCH;
                      vec_rst_d = 1'b0;
                      vec_id_d  = wake_id_i;
                    end
        PS_STARTUP: if (delay_done_i) begin
                      state_d   = PS_VFETCH;
                      vec_rst_d = 1'b1;
                      vec_id_d  = '0;
                    end
        PS_VFETCH:  state_d = PS_RUN;
        default:    state_d = PS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PS_RUN;
      vec_rst_q <= 1'b0;
      vec_id_q  <= '0;
      clr_q     <= 1'b0;
      full_q    <= 1'b0;
      wdg_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      vec_rst_q <= vec_rst_d;
      vec_id_q  <= vec_id_d;
      clr_q     <= in_run && halt_ok;
      full_q    <= in_run && halt_strobe_i && !mode_en_i;
      wdg_q     <= in_run && halt_strobe_i && mode_en_i && wdg_block;
    end
  end

  assign state_o        = state_q;
  assign vec_is_reset_o = vec_rst_q;
  assign vec_id_o       = vec_id_q;
  assign clr_imask_o    = clr_q;
  assign full_halt_o    = full_q;
  assign wdg_rst_o      = wdg_q;

  // R1: enabled halt enters the halted state
  a_r1_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RUN && halt_strobe_i && mode_en_i && !wdg_block && !rst_req_i)
    |=> (state_q == PS_HALTED));
  // R5: no exit without a wake source
  a_r5_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_HALTED && !rst_req_i && !wake_any_i) |=> (state_q == PS_HALTED));
  // R7: interrupt wake fetches an interrupt vector
  a_r7_irq_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_HALTED && !rst_req_i && wake_any_i)
    |=> (state_q == PS_VFETCH && !vec_rst_q));
  // R8: reset beats a simultaneous interrupt
  a_r8_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |=> (state_q == PS_STARTUP));
  // R6: start-up holds until the window ends
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_STARTUP && !delay_done_i) |=> (state_q == PS_STARTUP));
  // R13: vector fetch lasts one cycle
  a_r13_one_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_VFETCH && !rst_req_i) |=> (state_q == PS_RUN));
  // R10: disabled-mode halt leaves the run state alone
  a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (state_q == PS_RUN));
endmodule

// File: rtl/halt_clk_ctl.sv
// Clock-enable fan-out for CPU, peripherals and timer counters.
module halt_clk_ctl
  import halt_pkg::*;
#(
  parameter int              NUM_PERIPH   = 8,
  parameter logic [NUM_PERIPH-1:0] ALT_CLK_MASK = '0,
  parameter int              NUM_TMR      = 2,
  parameter int              TSW          = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  pstate_e               state_i,
  input  logic [TSW-1:0]        tmr_sel_i,
  output logic                  cpu_clk_en_o,
  output logic [NUM_PERIPH-1:0] periph_clk_en_o,
  output logic [NUM_TMR-1:0]    tmr_clk_en_o
);
  logic awake;

  assign awake        = (state_i == PS_RUN) || (state_i == PS_VFETCH);
  assign cpu_clk_en_o = awake;

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_periph
    assign periph_clk_en_o[p] = awake || ALT_CLK_MASK[p];
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign tmr_clk_en_o[t] = awake || (tmr_sel_i == TSW'(t));
  end
endmodule

// File: rtl/halt_power_seq.sv
// Top: timer-backed halt sequencer.
module halt_power_seq
  import halt_pkg::*;
#(
  parameter int              NUM_WAKE       = 4,
  parameter int              NUM_PERIPH     = 8,
  parameter logic [NUM_PERIPH-1:0] ALT_CLK_MASK = 8'h81,
  parameter int              NUM_TMR        = 2,
  parameter int              STARTUP_CYCLES = 64,
  localparam int             IDW = (NUM_WAKE > 1) ? $clog2(NUM_WAKE) : 1,
  localparam int             TSW = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  halt_strobe,
  input  logic                  halt_mode_en,
  input  logic                  wdg_active,
  input  logic                  wdg_halt_bit,
  input  logic                  rst_req,
  input  logic [NUM_WAKE-1:0]   wake_irq,
  input  logic [TSW-1:0]        tmr_sel,
  output logic                  cpu_clk_en,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic [NUM_TMR-1:0]    tmr_clk_en,
  output logic                  clr_imask,
  output logic                  vec_fetch,
  output logic                  vec_is_reset,
  output logic [IDW-1:0]        vec_id,
  output logic                  full_halt_req,
  output logic                  wdg_rst_req,
  output logic [1:0]            dbg_state
);
  logic [1:0]     rst_sync_q;
  logic           rst_sn;
  logic           wake_any, delay_done;
  logic [IDW-1:0] wake_id;
  pstate_e        state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  halt_wake_enc #(.NUM_WAKE(NUM_WAKE), .IDW(IDW)) u_enc (
    .irq_i (wake_irq),
    .any_o (wake_any),
    .id_o  (wake_id)
  );

  halt_delay_cnt #(.CYCLES(STARTUP_CYCLES)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sn),
    .clr_i  (rst_req),
    .run_i  (state == PS_STARTUP),
    .done_o (delay_done)
  );

  halt_fsm #(.IDW(IDW)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_sn),
    .halt_strobe_i  (halt_strobe),
    .mode_en_i      (halt_mode_en),
    .wdg_active_i   (wdg_active),
    .wdg_halt_bit_i (wdg_halt_bit),
    .rst_req_i      (rst_req),
    .wake_any_i     (wake_any),
    .wake_id_i      (wake_id),
    .delay_done_i   (delay_done),
    .state_o        (state),
    .vec_is_reset_o (vec_is_reset),
    .vec_id_o       (vec_id),
    .clr_imask_o    (clr_imask),
    .full_halt_o    (full_halt_req),
    .wdg_rst_o      (wdg_rst_req)
  );

  halt_clk_ctl #(
    .NUM_PERIPH(NUM_PERIPH), .ALT_CLK_MASK(ALT_CLK_MASK),
    .NUM_TMR(NUM_TMR), .TSW(TSW)
  ) u_clk (
    .state_i         (state),
    .tmr_sel_i       (tmr_sel),
    .cpu_clk_en_o    (cpu_clk_en),
    .periph_clk_en_o (periph_clk_en),
    .tmr_clk_en_o    (tmr_clk_en)
  );

  assign vec_fetch = (state == PS_VFETCH);
  assign dbg_state = state;

  // R2: mask-clear pulse only in the halted state
  a_r2_clr_in_halt: assert property (@(posedge clk) disable iff (!rst_sn)
    clr_imask |-> (dbg_state == 2'd1));
  // R4: CPU clock is off while halted or starting up
  a_r4_cpu_off: assert property (@(posedge clk) disable iff (!rst_sn)
    (dbg_state == 2'd1 || dbg_state == 2'd2) |-> !cpu_clk_en);
  // R4: only the selected timer keeps its clock while asleep
  a_r4_one_timer: assert property (@(posedge clk) disable iff (!rst_sn)
    !cpu_clk_en |-> ($countones(tmr_clk_en) == 1));
  // R11: watchdog reset never coincides with entering the halt
  a_r11_wdg_excl: assert property (@(posedge clk) disable iff (!rst_sn)
    wdg_rst_req |-> (dbg_state == 2'd0 && !clr_imask));
endmodule

// File: tb/halt_power_seq_test.sv
module halt_power_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ALT = 8'h81;

  logic       clk = 1'b0;
  logic       rst_n, halt_strobe, halt_mode_en, wdg_active, wdg_halt_bit, rst_req;
  logic [3:0] wake_irq;
  logic [0:0] tmr_sel;
  logic       cpu_clk_en, clr_imask, vec_fetch, vec_is_reset, full_halt_req, wdg_rst_req;
  logic [7:0] periph_clk_en;
  logic [1:0] tmr_clk_en, vec_id, dbg_state;
  int         n_chk = 0;
  int         n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_power_seq uut (
    .clk(clk), .rst_n(rst_n), .halt_strobe(halt_strobe), .halt_mode_en(halt_mode_en),
    .wdg_active(wdg_active), .wdg_halt_bit(wdg_halt_bit), .rst_req(rst_req),
    .wake_irq(wake_irq), .tmr_sel(tmr_sel), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .tmr_clk_en(tmr_clk_en), .clr_imask(clr_imask),
    .vec_fetch(vec_fetch), .vec_is_reset(vec_is_reset), .vec_id(vec_id),
    .full_halt_req(full_halt_req), .wdg_rst_req(wdg_rst_req), .dbg_state(dbg_state)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // enter halt from run; after return, first halted cycle is visible
  task automatic enter_halt(input logic [3:0] irq);
    halt_strobe = 1'b1; halt_mode_en = 1'b1; wake_irq = irq;
    step();
    halt_strobe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 reset state", dbg_state, 2'd0);
    chk("R12 reset fetch", vec_fetch, 1'b0);
    chk("R4 run cpu clk", cpu_clk_en, 1'b1);
    chk("R4 run periph", periph_clk_en, 8'hFF);
    chk("R4 run timers", tmr_clk_en, 2'b11);
  endtask

  task automatic t_irq_wake();
    tmr_sel = 1'b1;
    enter_halt(4'b0000);
    chk("R1 halted", dbg_state, 2'd1);
    chk("R1 cpu off", cpu_clk_en, 1'b0);
    chk("R2 mask clear", clr_imask, 1'b1);
    chk("R4 halt periph", periph_clk_en, ALT);
    chk("R4 halt timer", tmr_clk_en, 2'b10);
    halt_strobe = 1'b1; halt_mode_en = 1'b0;
    step();
    halt_strobe = 1'b0;
    chk("R2 one cycle", clr_imask, 1'b0);
    step();
    chk("R5 still halted", dbg_state, 2'd1);
    chk("R5 no full halt", full_halt_req, 1'b0);
    wake_irq = 4'b0110;
    step();
    wake_irq = 4'b0000;
    chk("R7 fetch", vec_fetch, 1'b1);
    chk("R7 irq vector", vec_is_reset, 1'b0);
    chk("R7 lowest id", vec_id, 2'd1);
    chk("R4 fetch cpu clk", cpu_clk_en, 1'b1);
    step();
    chk("R13 back to run", dbg_state, 2'd0);
  endtask

  task automatic t_pending();
    tmr_sel = 1'b0;
    enter_halt(4'b1000);
    chk("R3 halted once", dbg_state, 2'd1);
    chk("R4 timer sel 0", tmr_clk_en, 2'b01);
    step();
    wake_irq = 4'b0000;
    chk("R3 immediate wake", vec_fetch, 1'b1);
    chk("R3 id", vec_id, 2'd3);
    step();
  endtask

  task automatic t_reset_wake();
    enter_halt(4'b0000);
    step();
    rst_req = 1'b1;
    step();
    rst_req = 1'b0;
    chk("R6 startup", dbg_state, 2'd2);
    chk("R6 cpu held", cpu_clk_en, 1'b0);
    chk("R4 startup periph", periph_clk_en, ALT);
    repeat (63) step();
    chk("R6 still held at 64", cpu_clk_en, 1'b0);
    step();
    chk("R6 fetch", vec_fetch, 1'b1);
    chk("R6 reset vector", vec_is_reset, 1'b1);
    chk("R6 cpu on", cpu_clk_en, 1'b1);
    step();
    chk("R13 run after reset fetch", dbg_state, 2'd0);
  endtask

  task automatic t_restart();
    rst_req = 1'b1;
    step();
    rst_req = 1'b0;
    repeat (20) step();
    rst_req = 1'b1;
    step();
    rst_req = 1'b0;
    repeat (63) step();
    chk("R9 restarted", dbg_state, 2'd2);
    step();
    chk("R9 fetch after restart", vec_fetch, 1'b1);
    step();
  endtask

  task automatic t_collide();
    enter_halt(4'b0000);
    rst_req = 1'b1; wake_irq = 4'b0001;
    step();
    rst_req = 1'b0; wake_irq = 4'b0000;
    chk("R8 reset wins", dbg_state, 2'd2);
    chk("R8 no fetch", vec_fetch, 1'b0);
    repeat (64) step();
    chk("R8 reset vector", vec_is_reset, 1'b1);
    step();
  endtask

  task automatic t_ignored();
    halt_strobe = 1'b1; halt_mode_en = 1'b0;
    step();
    halt_strobe = 1'b0;
    chk("R10 stays run", dbg_state, 2'd0);
    chk("R10 flag", full_halt_req, 1'b1);
    chk("R10 periph on", periph_clk_en, 8'hFF);
    chk("R10 no mask clear", clr_imask, 1'b0);
    step();
    chk("R10 flag pulse", full_halt_req, 1'b0);
  endtask

  task automatic t_wdg();
    wdg_active = 1'b1; wdg_halt_bit = 1'b1;
    halt_strobe = 1'b1; halt_mode_en = 1'b1;
    step();
    halt_strobe = 1'b0;
    chk("R11 blocked run", dbg_state, 2'd0);
    chk("R11 wdg reset", wdg_rst_req, 1'b1);
    step();
    chk("R11 wdg pulse", wdg_rst_req, 1'b0);
    wdg_halt_bit = 1'b0;
    enter_halt(4'b0000);
    chk("R11 halted", dbg_state, 2'd1);
    chk("R11 no wdg reset", wdg_rst_req, 1'b0);
    wake_irq = 4'b0100;
    step();
    wake_irq = 4'b0000;
    step();
    wdg_active = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; halt_strobe = 1'b0; halt_mode_en = 1'b0; wdg_active = 1'b0;
    wdg_halt_bit = 1'b0; rst_req = 1'b0; wake_irq = '0; tmr_sel = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_irq_wake();
    t_pending();
    t_reset_wake();
    t_restart();
    t_collide();
    t_ignored();
    t_wdg();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule